// File: doc/BRIEF.md
# Programmable Pixel Color Converter

This block sits in a display pipe and converts RGB pixels one at a time. Each pixel carries three 8-bit components. A pixel on its way through the converter gets a signed offset added to each component. The result is then multiplied by a programmable 3x3 gain matrix. Last, each output channel gets either its own programmable offset or a fixed lift of 16 levels. The result is rounded and clamped back to 8 bits. The usual job is to turn full-range 0..255 RGB into limited-range 16..235 video levels. The matrix can also serve as a general color-correction stage.

Each pixel arrives with a per-pixel enable that comes from the control word of its source plane. When the enable is clear, the pixel leaves after the same latency with no change. Configuration is written through a 32-bit register port into staging registers. A frame-start strobe copies the staging set into the working set, so a frame is never converted with a mix of old and new settings. The staging set can be read back through a combinational read port.

Top module: `csc_pixel_top`

## Requirements
- R1: When pix_in_csc_en is 0, the three output components equal the input components exactly, with the same latency as converted pixels.
- R2: pix_out_valid is 0 after reset and goes high exactly 3 clock edges after the edge that samples pix_in_valid high (one output per input, no other valid outputs).
- R3: Coefficients are 16 bits: bit 15 = sign (1 = negative), bits 14:12 = scale selector, bits 11:3 = mantissa m. The gain is m/512 times ×1 (sel 0), ×1/2 (sel 1), ×1/4 (sel 2), ×1/8 (sel 3) or ×2 (sel 7), and zero for sel 4..6. So 0x7800 is a gain of exactly 1.0, and the identity matrix passes pixels unchanged.
- R4: Output channel i = sum over j of coef[i][j] × (in[j] + pre[j]), plus the channel's final offset. The offset is added after the multiply.
- R5: Pre-offsets and post-offsets are 13-bit two's-complement values in units of 1/32 level. The pre-offset is added before the matrix and the post-offset after it.
- R6: Mode bit 2 set replaces the post-offsets with a fixed lift of +16 levels. With gain 0xDB8 (439/512) on the diagonal, inputs 0, 128 and 255 map to 16, 126 and 235.
- R7: The final value is rounded to nearest, with halves rounded up, and saturated to the range 0..255.
- R8: Register writes only change the staging set. The values used for pixels change on the first edge at which frame_start is 1.
- R9: The register map is by word address. Matrix row r (r = 0..2) is held at address 2r: bits 31:16 hold coef[r][0] and bits 15:0 hold coef[r][1]. Address 2r+1 holds coef[r][2] in bits 15:0. The mode word is at 6 (bits 2:0). Pre-offsets for channels 0..2 are at 7..9 and post-offsets at 10..12, each in bits 12:0. Bits that are not stored read back as 0, and so do unused addresses.
- R10: Mode bits 0 and 1 are stored and read back but have no effect on the output pixels.
- R11: After reset all coefficients, offsets and the mode word are zero in both the staging and the working set. An enabled pixel then comes out as 0,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 4 | Register write word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 4 | Register read word address |
| cfg_rdata | output | 32 | Staging register read data (combinational) |
| frame_start | input | 1 | Copies the staging set into the working set |
| pix_in_valid | input | 1 | Input pixel qualifier |
| pix_in_csc_en | input | 1 | 1 = convert this pixel, 0 = pass it unchanged |
| pix_in_c0 | input | 8 | Input component 0 |
| pix_in_c1 | input | 8 | Input component 1 |
| pix_in_c2 | input | 8 | Input component 2 |
| pix_out_valid | output | 1 | Output pixel qualifier |
| pix_out_c0 | output | 8 | Output component 0 |
| pix_out_c1 | output | 8 | Output component 1 |
| pix_out_c2 | output | 8 | Output component 2 |

## Verification
Any wrong value in the working set shows on the pixel outputs of the next converted pixel, three edges after it enters. A corrupted coefficient or offset moves one output channel by a predictable amount. A shadow copy taken at the wrong time shows as new values appearing before frame_start, or old values lingering after it. A broken valid or bypass path shows within the same three-cycle window: a missing or extra pix_out_valid, or a bypassed pixel that comes out changed. Faults that appear only near the ends of the range are exposed by the clamp and rounding corners, such as a negative sum, a sum above 255 and an exact half-level result.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int PIX_W       = 8;
    localparam int CH          = 3;
    localparam int COEF_W      = 16;
    localparam int OFF_W       = 13;
    localparam int MANT_W      = 9;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 32;
    localparam int MODE_W      = 3;
    localparam int MODE_LIFT   = 2;
    localparam int LIFT_LEVELS = 16;
    localparam int UNITY_SH    = 3;                          // shift for scale x1
    localparam int LVL_SH      = OFF_W - PIX_W;              // 1/32-level units
    localparam int PRE_W       = PIX_W + LVL_SH + 3;
    localparam int ACC_W       = 32;
    localparam int POST_SH     = MANT_W + UNITY_SH;
    localparam int FRAC_SH     = LVL_SH + POST_SH;           // one level = 2**FRAC_SH

    localparam int C_SIGN    = 15;
    localparam int C_SEL_HI  = 14;
    localparam int C_SEL_LO  = 12;
    localparam int C_MANT_HI = 11;
    localparam int C_MANT_LO = 3;

    localparam logic [ADDR_W-1:0] A_MODE      = ADDR_W'(2 * CH);
    localparam logic [ADDR_W-1:0] A_PRE_BASE  = ADDR_W'(2 * CH + 1);
    localparam logic [ADDR_W-1:0] A_POST_BASE = ADDR_W'(3 * CH + 1);

    typedef logic [COEF_W-1:0] coef_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef struct packed {
        coef_t [CH-1:0][CH-1:0] coef;
        off_t  [CH-1:0]         pre;
        off_t  [CH-1:0]         post;
        logic  [MODE_W-1:0]     mode;
    } cfg_t;

    function automatic logic signed [ACC_W-1:0] coef_term(
        input logic signed [PRE_W-1:0] a,
        input coef_t                   c
    );
        logic signed [ACC_W-1:0] ax;
        logic signed [ACC_W-1:0] mx;
        logic signed [ACC_W-1:0] p;
        logic signed [ACC_W-1:0] r;
        ax = ACC_W'(a);
        mx = ACC_W'({1'b0, c[C_MANT_HI:C_MANT_LO]});
        p  = ax * mx;
        case (c[C_SEL_HI:C_SEL_LO])
            3'd0:    r = p <<< UNITY_SH;
            3'd1:    r = p <<< (UNITY_SH - 1);
            3'd2:    r = p <<< (UNITY_SH - 2);
            3'd3:    r = p;
            3'd7:    r = p <<< (UNITY_SH + 1);
            default: r = '0;
        endcase
        return c[C_SIGN] ? -r : r;
    endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              frame_start_i,
    output cfg_t              act_o
);
    typedef struct packed {
        cfg_t stage;
        cfg_t act;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (we_i) begin
            for (int r = 0; r < CH; r++) begin
                if (waddr_i == ADDR_W'(2 * r)) begin
                    d.stage.coef[r][0] = wdata_i[2*COEF_W-1:COEF_W];
                    d.stage.coef[r][1] = wdata_i[COEF_W-1:0];
                end
                if (waddr_i == ADDR_W'(2 * r + 1))
                    d.stage.coef[r][2] = wdata_i[COEF_W-1:0];
                if (waddr_i == A_PRE_BASE + ADDR_W'(r))
                    d.stage.pre[r] = wdata_i[OFF_W-1:0];
                if (waddr_i == A_POST_BASE + ADDR_W'(r))
                    d.stage.post[r] = wdata_i[OFF_W-1:0];
            end
            if (waddr_i == A_MODE)
                d.stage.mode = wdata_i[MODE_W-1:0];
        end
        if (frame_start_i)
            d.act = q.stage;
    end

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < CH; r++) begin
            if (raddr_i == ADDR_W'(2 * r))
                rdata_o = {q.stage.coef[r][0], q.stage.coef[r][1]};
            if (raddr_i == ADDR_W'(2 * r + 1))
                rdata_o = DATA_W'(q.stage.coef[r][2]);
            if (raddr_i == A_PRE_BASE + ADDR_W'(r))
                rdata_o = DATA_W'(q.stage.pre[r]);
            if (raddr_i == A_POST_BASE + ADDR_W'(r))
                rdata_o = DATA_W'(q.stage.post[r]);
        end
        if (raddr_i == A_MODE)
            rdata_o = DATA_W'(q.stage.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_o = q.act;

    // R8: working set only moves on frame_start
    p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(act_o));
    // R8: frame_start loads the staging set as it was before the edge
    p_act_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (act_o == $past(q.stage)));
endmodule

// File: rtl/csc_pre_stage.sv
module csc_pre_stage
    import csc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           vld_i,
    input  logic                           en_i,
    input  logic [CH-1:0][PIX_W-1:0]       pix_i,
    input  off_t [CH-1:0]                  pre_i,
    output logic                           vld_o,
    output logic                           byp_o,
    output logic [CH-1:0][PIX_W-1:0]       raw_o,
    output logic [CH-1:0][PRE_W-1:0]       a_o
);
    typedef struct packed {
        logic                     vld;
        logic                     byp;
        logic [CH-1:0][PIX_W-1:0] raw;
        logic [CH-1:0][PRE_W-1:0] a;
    } s1_t;

    s1_t q, d;

    always_comb begin
        logic signed [PRE_W-1:0] px;
        logic signed [PRE_W-1:0] po;
        d     = q;
        d.vld = vld_i;
        d.byp = !en_i;
        d.raw = pix_i;
        for (int c = 0; c < CH; c++) begin
            px     = PRE_W'({pix_i[c], {LVL_SH{1'b0}}});
            po     = PRE_W'($signed(pre_i[c]));
            d.a[c] = px + po;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vld_o = q.vld;
    assign byp_o = q.byp;
    assign raw_o = q.raw;
    assign a_o   = q.a;
endmodule

// File: rtl/csc_row_pipe.sv
module csc_row_pipe
    import csc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_vld_i,
    input  logic                     s1_byp_i,
    input  logic [PIX_W-1:0]         s1_raw_i,
    input  logic [CH-1:0][PRE_W-1:0] s1_a_i,
    input  coef_t [CH-1:0]           coef_i,
    input  off_t                     post_i,
    input  logic                     lift_i,
    output logic                     vld_o,
    output logic [PIX_W-1:0]         pix_o
);
    localparam logic signed [ACC_W-1:0] LIFT_FIX   = ACC_W'(LIFT_LEVELS) <<< FRAC_SH;
    localparam logic signed [ACC_W-1:0] ROUND_HALF = ACC_W'(1) <<< (FRAC_SH - 1);
    localparam logic signed [ACC_W-1:0] PIX_MAX    = ACC_W'((1 << PIX_W) - 1);
    localparam logic signed [ACC_W-1:0] HI_SURE    = ACC_W'(3 << PIX_W) <<< FRAC_SH;
    localparam logic signed [ACC_W-1:0] LO_SURE    = -(ACC_W'(1 << (PIX_W - 1)) <<< FRAC_SH);

    typedef struct packed {
        logic                    s2_vld;
        logic                    s2_byp;
        logic [PIX_W-1:0]        s2_raw;
        logic signed [ACC_W-1:0] s2_acc;
        logic                    o_vld;
        logic [PIX_W-1:0]        o_pix;
    } row_t;

    row_t q, d;

    always_comb begin
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] fin;
        logic signed [ACC_W-1:0] lvl;
        d        = q;
        d.s2_vld = s1_vld_i;
        d.s2_byp = s1_byp_i;
        d.s2_raw = s1_raw_i;
        acc      = '0;
        for (int j = 0; j < CH; j++)
            acc = acc + coef_term($signed(s1_a_i[j]), coef_i[j]);
        d.s2_acc = acc;

        fin = q.s2_acc + (lift_i ? LIFT_FIX : (ACC_W'($signed(post_i)) <<< POST_SH));
        lvl = (fin + ROUND_HALF) >>> FRAC_SH;
        d.o_vld = q.s2_vld;
        if (q.s2_byp)          d.o_pix = q.s2_raw;
        else if (lvl < 0)      d.o_pix = '0;
        else if (lvl > PIX_MAX) d.o_pix = PIX_MAX[PIX_W-1:0];
        else                   d.o_pix = lvl[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vld_o = q.o_vld;
    assign pix_o = q.o_pix;

    // R1: bypassed component leaves unchanged two edges after stage one
    p_bypass_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld_i && s1_byp_i) |=> ##1 (pix_o == $past(s1_raw_i, 2)));
    // R2: stage-one valid reaches the output after two more edges
    p_valid_flow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld_i |=> ##1 vld_o);
    // R7: a sum far above full scale saturates high whatever the offset
    p_clamp_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s2_vld && !q.s2_byp && q.s2_acc >= HI_SURE) |=> (pix_o == PIX_MAX[PIX_W-1:0]));
    // R7: a sum far below zero saturates low whatever the offset
    p_clamp_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s2_vld && !q.s2_byp && q.s2_acc <= LO_SURE) |=> (pix_o == '0));
endmodule

// File: rtl/csc_pixel_top.sv
module csc_pixel_top
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_waddr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              frame_start,
    input  logic              pix_in_valid,
    input  logic              pix_in_csc_en,
    input  logic [PIX_W-1:0]  pix_in_c0,
    input  logic [PIX_W-1:0]  pix_in_c1,
    input  logic [PIX_W-1:0]  pix_in_c2,
    output logic              pix_out_valid,
    output logic [PIX_W-1:0]  pix_out_c0,
    output logic [PIX_W-1:0]  pix_out_c1,
    output logic [PIX_W-1:0]  pix_out_c2
);
    cfg_t                     act;
    logic                     s1_vld;
    logic                     s1_byp;
    logic [CH-1:0][PIX_W-1:0] s1_raw;
    logic [CH-1:0][PRE_W-1:0] s1_a;
    logic [CH-1:0]            row_vld;
    logic [CH-1:0][PIX_W-1:0] row_pix;

    csc_cfg_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (cfg_we),
        .waddr_i       (cfg_waddr),
        .wdata_i       (cfg_wdata),
        .raddr_i       (cfg_raddr),
        .rdata_o       (cfg_rdata),
        .frame_start_i (frame_start),
        .act_o         (act)
    );

    csc_pre_stage u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (pix_in_valid),
        .en_i  (pix_in_csc_en),
        .pix_i ({pix_in_c2, pix_in_c1, pix_in_c0}),
        .pre_i (act.pre),
        .vld_o (s1_vld),
        .byp_o (s1_byp),
        .raw_o (s1_raw),
        .a_o   (s1_a)
    );

    for (genvar r = 0; r < CH; r++) begin : g_row
        csc_row_pipe u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .s1_vld_i (s1_vld),
            .s1_byp_i (s1_byp),
            .s1_raw_i (s1_raw[r]),
            .s1_a_i   (s1_a),
            .coef_i   ({act.coef[r][2], act.coef[r][1], act.coef[r][0]}),
            .post_i   (act.post[r]),
            .lift_i   (act.mode[MODE_LIFT]),
            .vld_o    (row_vld[r]),
            .pix_o    (row_pix[r])
        );
    end

    assign pix_out_valid = row_vld[0];
    assign pix_out_c0    = row_pix[0];
    assign pix_out_c1    = row_pix[1];
    assign pix_out_c2    = row_pix[2];

    // R2: fixed three-edge latency from the input port
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_in_valid |=> ##2 pix_out_valid);
    // R2: no output without an input three edges earlier
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_in_valid |=> ##2 !pix_out_valid);
    // R2: all channel pipes stay aligned
    p_rows_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_vld == '0) || (row_vld == '1));
endmodule

// File: tb/csc_pixel_top_tb_top.sv
module csc_pixel_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        frame_start = 1'b0;
    logic        pix_in_valid = 1'b0;
    logic        pix_in_csc_en = 1'b0;
    logic [7:0]  pix_in_c0 = '0, pix_in_c1 = '0, pix_in_c2 = '0;
    logic        pix_out_valid;
    logic [7:0]  pix_out_c0, pix_out_c1, pix_out_c2;

    int checks = 0;
    int failures = 0;

    // bench-side model of the configuration
    logic [15:0] st_coef [3][3];
    logic [12:0] st_pre [3];
    logic [12:0] st_post [3];
    logic [2:0]  st_mode;
    logic [15:0] ac_coef [3][3];
    logic [12:0] ac_pre [3];
    logic [12:0] ac_post [3];
    logic [2:0]  ac_mode;

    always #(CLK_PERIOD / 2) clk = ~clk;

    csc_pixel_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .frame_start(frame_start),
        .pix_in_valid(pix_in_valid), .pix_in_csc_en(pix_in_csc_en),
        .pix_in_c0(pix_in_c0), .pix_in_c1(pix_in_c1), .pix_in_c2(pix_in_c2),
        .pix_out_valid(pix_out_valid),
        .pix_out_c0(pix_out_c0), .pix_out_c1(pix_out_c1), .pix_out_c2(pix_out_c2)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real gain(input logic [15:0] c);
        real g;
        g = real'(c[11:3]) / 512.0;
        case (c[14:12])
            3'd0: g = g;
            3'd1: g = g / 2.0;
            3'd2: g = g / 4.0;
            3'd3: g = g / 8.0;
            3'd7: g = g * 2.0;
            default: g = 0.0;
        endcase
        return c[15] ? -g : g;
    endfunction

    function automatic real off_lv(input logic [12:0] o);
        int v;
        v = o[12] ? int'(o) - 8192 : int'(o);
        return real'(v) / 32.0;
    endfunction

    function automatic int model(input int ch, input int x0, input int x1, input int x2);
        real v;
        int  xs [3];
        int  r;
        xs[0] = x0; xs[1] = x1; xs[2] = x2;
        v = 0.0;
        for (int j = 0; j < 3; j++)
            v = v + gain(ac_coef[ch][j]) * (real'(xs[j]) + off_lv(ac_pre[j]));
        v = v + (ac_mode[2] ? 16.0 : off_lv(ac_post[ch]));
        r = int'($floor(v + 0.5));
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] dat);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = dat;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            4'd0, 4'd2, 4'd4: begin
                st_coef[a/2][0] = dat[31:16];
                st_coef[a/2][1] = dat[15:0];
            end
            4'd1, 4'd3, 4'd5: st_coef[a/2][2] = dat[15:0];
            4'd6: st_mode = dat[2:0];
            4'd7, 4'd8, 4'd9: st_pre[a-7] = dat[12:0];
            4'd10, 4'd11, 4'd12: st_post[a-10] = dat[12:0];
            default: ;
        endcase
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        ac_coef = st_coef; ac_pre = st_pre; ac_post = st_post; ac_mode = st_mode;
    endtask

    task automatic set_mat(input logic [0:8][15:0] m);
        for (int r = 0; r < 3; r++) begin
            wr(4'(2 * r), {m[3*r], m[3*r+1]});
            wr(4'(2 * r + 1), {16'h0, m[3*r+2]});
        end
    endtask

    task automatic set_offs(input logic [12:0] p0, p1, p2, q0, q1, q2);
        wr(4'd7, 32'(p0)); wr(4'd8, 32'(p1)); wr(4'd9, 32'(p2));
        wr(4'd10, 32'(q0)); wr(4'd11, 32'(q1)); wr(4'd12, 32'(q2));
    endtask

    // sends one pixel, checks latency and the three components
    task automatic pixel(input string req, input logic en, input int x0, x1, x2);
        int e0, e1, e2;
        if (en) begin
            e0 = model(0, x0, x1, x2); e1 = model(1, x0, x1, x2); e2 = model(2, x0, x1, x2);
        end else begin
            e0 = x0; e1 = x1; e2 = x2;
        end
        @(negedge clk);
        pix_in_valid = 1'b1; pix_in_csc_en = en;
        pix_in_c0 = 8'(x0); pix_in_c1 = 8'(x1); pix_in_c2 = 8'(x2);
        @(posedge clk);
        @(negedge clk);
        pix_in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2 valid early", int'(pix_out_valid), 0);
        @(negedge clk);
        chk("R2 valid on time", int'(pix_out_valid), 1);
        chk({req, " c0"}, int'(pix_out_c0), e0);
        chk({req, " c1"}, int'(pix_out_c1), e1);
        chk({req, " c2"}, int'(pix_out_c2), e2);
        @(negedge clk);
        chk("R2 single valid", int'(pix_out_valid), 0);
    endtask

    task automatic t_reset();   // R11
        chk("R11 out valid after reset", int'(pix_out_valid), 0);
        for (int a = 0; a < 16; a++) begin
            cfg_raddr = 4'(a);
            #1;
            chk("R11 register reset", int'(cfg_rdata), 0);
        end
        pixel("R11 zero matrix", 1'b1, 200, 100, 50);
    endtask

    task automatic t_readback();   // R9
        set_mat({16'h1234, 16'h5678, 16'h9abc, 16'h0011, 16'h0022, 16'h0033,
                 16'h0044, 16'h0055, 16'hfff8});
        wr(4'd7, 32'hffff_ffff);
        wr(4'd12, 32'h0000_1abc);
        wr(4'd6, 32'hffff_fffd);
        cfg_raddr = 4'd0;  #1; chk("R9 row0 pair", int'(cfg_rdata), int'(32'h1234_5678));
        cfg_raddr = 4'd1;  #1; chk("R9 row0 third", int'(cfg_rdata), int'(32'h0000_9abc));
        cfg_raddr = 4'd5;  #1; chk("R9 row2 third", int'(cfg_rdata), int'(32'h0000_fff8));
        cfg_raddr = 4'd7;  #1; chk("R9 pre trimmed", int'(cfg_rdata), int'(32'h0000_1fff));
        cfg_raddr = 4'd12; #1; chk("R9 post ch2", int'(cfg_rdata), int'(32'h0000_1abc));
        cfg_raddr = 4'd6;  #1; chk("R9 mode bits", int'(cfg_rdata), 5);
        cfg_raddr = 4'd13; #1; chk("R9 unused addr", int'(cfg_rdata), 0);
        wr(4'd7, 32'h0); wr(4'd12, 32'h0); wr(4'd6, 32'h0);
    endtask

    task automatic t_bypass();   // R1
        pixel("R1 bypass", 1'b0, 17, 250, 3);
        pixel("R1 bypass extremes", 1'b0, 0, 255, 128);
    endtask

    task automatic t_unity();   // R3
        set_mat({16'h7800, 16'h0, 16'h0, 16'h0, 16'h7800, 16'h0, 16'h0, 16'h0, 16'h7800});
        set_offs(13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0);
        wr(4'd6, 32'h0);
        frame();
        pixel("R3 unity", 1'b1, 0, 127, 255);
        pixel("R3 unity mid", 1'b1, 1, 200, 99);
    endtask

    task automatic t_mode_inert();   // R10
        wr(4'd6, 32'h3);
        frame();
        cfg_raddr = 4'd6; #1; chk("R10 mode readback", int'(cfg_rdata), 3);
        pixel("R10 low mode bits inert", 1'b1, 10, 128, 240);
        wr(4'd6, 32'h0);
        frame();
    endtask

    task automatic t_shadow();   // R8
        set_mat({16'h0800, 16'h0, 16'h0, 16'h0, 16'h0800, 16'h0, 16'h0, 16'h0, 16'h0800});
        pixel("R8 before frame_start", 1'b1, 100, 60, 200);
        chk("R8 old gain c0", int'(pix_out_c0), 100);
        frame();
        pixel("R8 after frame_start", 1'b1, 100, 60, 200);
        chk("R8 new gain c0", int'(pix_out_c0), 50);
    endtask

    task automatic t_matrix();   // R3 R4 R7
        set_mat({16'h0000, 16'h0800, 16'h0800,
                 16'h7800, 16'h8800, 16'h0000,
                 16'h0000, 16'h4ff8, 16'h1800});
        frame();
        pixel("R4 cross terms", 1'b1, 200, 100, 50);
        chk("R4 c0 avg", int'(pix_out_c0), 75);
        chk("R4 c1 diff", int'(pix_out_c1), 150);
        chk("R7 half rounds up", int'(pix_out_c2), 13);
        set_mat({16'h7ff8, 16'h0, 16'h0, 16'h0, 16'h8800, 16'h0, 16'h0, 16'h0, 16'h3ff8});
        frame();
        pixel("R7 saturation", 1'b1, 200, 100, 77);
        chk("R7 clamp high", int'(pix_out_c0), 255);
        chk("R7 clamp low", int'(pix_out_c1), 0);
    endtask

    task automatic t_pre();   // R5
        set_mat({16'h0800, 16'h0, 16'h0, 16'h0, 16'h7800, 16'h0, 16'h0, 16'h0, 16'h0800});
        set_offs(13'd1024, 13'h19c0, 13'h0, 13'h0, 13'h0, 13'h0);
        frame();
        pixel("R5 pre-offset", 1'b1, 100, 100, 100);
        chk("R5 pre before gain", int'(pix_out_c0), 66);
        chk("R5 negative pre", int'(pix_out_c1), 50);
        set_offs(13'h0, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0);
    endtask

    task automatic t_limited();   // R5 R6
        set_mat({16'h0db8, 16'h0, 16'h0, 16'h0, 16'h0db8, 16'h0, 16'h0, 16'h0, 16'h0db8});
        set_offs(13'h0, 13'h0, 13'h0, 13'd514, 13'd514, 13'd514);
        frame();
        pixel("R5 post-offset", 1'b1, 0, 255, 100);
        chk("R5 post black", int'(pix_out_c0), 16);
        chk("R5 post white", int'(pix_out_c1), 235);
        set_offs(13'h0, 13'h0, 13'h0, 13'd3000, 13'h1000, 13'd1);
        wr(4'd6, 32'h4);
        frame();
        pixel("R6 black lift", 1'b1, 0, 128, 255);
        chk("R6 lift 0", int'(pix_out_c0), 16);
        chk("R6 lift 128", int'(pix_out_c1), 126);
        chk("R6 lift 255", int'(pix_out_c2), 235);
        pixel("R1 bypass ignores lift", 1'b0, 0, 128, 255);
    endtask

    initial begin
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 3; j++) begin
                st_coef[r][j] = '0; ac_coef[r][j] = '0;
            end
            st_pre[r] = '0; st_post[r] = '0; ac_pre[r] = '0; ac_post[r] = '0;
        end
        st_mode = '0; ac_mode = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_bypass();
        t_unity();
        t_mode_inert();
        t_shadow();
        t_matrix();
        t_pre();
        t_limited();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule